// File: doc/BRIEF.md
# Waveform-table LED brightness sequencer

This block sets the brightness of an indicator LED. A 64-entry table of brightness bytes sits in local storage. A host loads the table in bursts: each burst names a start entry and a byte count, and the data bytes follow. When sequencing is enabled, a pointer walks through the table. Each table entry becomes the current brightness level in turn. A pulse-width modulator turns that level into the LED drive pin.

The pointer moves on a 4 MHz tick enable, through two prescaler stages in cascade. The first stage is a 16-bit counter that restarts from a reload value. The second stage divides by DIV+1. After the last entry the pointer either wraps to entry 0, or the sequence halts. While sequencing is off or halted, the level comes from a brightness register written directly. A pulse on the configuration-start input stops sequencing at once.

Top module: `led_wave_seq`

## Requirements
- R1: After reset, bright_level is 0x00, seq_active is 0, seq_index is 0, led_pwm stays low, and every table entry is 0x00.
- R2: A pulse on tbl_start sets the first entry to tbl_offset and the byte budget to tbl_count. A budget above 61 is cut to 61. Each later tbl_vld byte goes to the next entry in rising order. Bytes beyond the budget are dropped. Bytes that would land past entry 63 are dropped and do not wrap to entry 0.
- R3: While sequencing, seq_index advances by one every (0x10000 − ctl_reload) × (ctl_div + 1) tick_en pulses. ctl_reload bits [7:0] carry the low byte, which is the byte received first.
- R4: When the repeat flag latched at enable is 1, a step taken at entry 63 returns seq_index to 0 and sequencing continues.
- R5: When the repeat flag is 0, a step taken at entry 63 ends sequencing. seq_active falls, seq_index stays at 63, and bright_level shows the direct brightness register.
- R6: A control write with ctl_enable=1 starts sequencing. It sets seq_index to 0 and restarts both prescaler stages from the new reload and divisor. While sequencing, bright_level equals the table entry at seq_index.
- R7: A control write with ctl_enable=0 stops sequencing whatever values ctl_reload, ctl_div and ctl_repeat carry. seq_index then holds its value, and later ticks do not move it.
- R8: bright_wr loads the direct brightness register, where 0x00 means off, 0xFF means full and 0x19 means dimmed. The value is shown at once when not sequencing. While sequencing it is stored but not shown.
- R9: A cfg_start pulse ends sequencing on the next clock. It wins over an enabling control write in the same cycle.
- R10: Over any 256 consecutive clocks at a steady level L, led_pwm is high on exactly L clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse at the 4 MHz step-timer rate |
| tbl_start | input | 1 | Begins a table burst |
| tbl_offset | input | 6 | First table entry of the burst |
| tbl_count | input | 6 | Byte budget of the burst |
| tbl_vld | input | 1 | A table data byte is present |
| tbl_data | input | 8 | Table data byte |
| ctl_wr | input | 1 | Control write strobe |
| ctl_enable | input | 1 | 1 starts sequencing, 0 stops it |
| ctl_reload | input | 16 | First-stage reload; bits [7:0] are the first byte received |
| ctl_div | input | 8 | Second-stage divisor minus one |
| ctl_repeat | input | 1 | 1 loops the waveform, 0 plays it once |
| bright_wr | input | 1 | Direct brightness write strobe |
| bright_data | input | 8 | Direct brightness value |
| cfg_start | input | 1 | Configuration start; forces sequencing off |
| bright_level | output | 8 | Current brightness level |
| seq_active | output | 1 | Sequencing is running |
| seq_index | output | 6 | Current table pointer |
| led_pwm | output | 1 | LED drive |

## Verification
The assertions assume that tick_en is a single-cycle pulse. They also assume that tbl_start never arrives in the same cycle as a data byte, and that control writes and cfg_start are single-cycle strobes. The bench drives every strobe for exactly one clock and separates each tick pulse with an idle cycle. It never overlaps a burst start with data. The pointer-stability property allows for a step on any tick, so sparse ticks can only make it easier to satisfy.

// File: rtl/led_seq_pkg.sv
// Package: shared defaults and sequencer state encoding for the LED waveform
// sequencer. Assumes nothing; holds constants and types only.
package led_seq_pkg;
    localparam int unsigned LS_DEPTH     = 64;
    localparam int unsigned LS_DATA_W    = 8;
    localparam int unsigned LS_RELOAD_W  = 16;
    localparam int unsigned LS_DIV_W     = 8;
    localparam int unsigned LS_MAX_BURST = 61;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/wave_table.sv
// wave_table: brightness table storage plus a burst writer. A burst begins
// with a start pulse that carries an offset and a byte budget; each later
// valid byte goes to the next entry. Budgets above MAX_BURST are clamped.
// Bytes past the last entry are dropped. The read port is combinational.
// Assumes start and a data byte never arrive in the same cycle.
module wave_table #(
    parameter int unsigned DEPTH     = 64,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned MAX_BURST = 61,
    localparam int unsigned AW       = $clog2(DEPTH),
    localparam int unsigned CW       = $clog2(MAX_BURST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_start,
    input  logic [AW-1:0]     burst_offset,
    input  logic [CW-1:0]     burst_count,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic [AW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [AW-1:0] LAST_ENTRY = AW'(DEPTH - 1);
    localparam logic [CW-1:0] BURST_CAP  = CW'(MAX_BURST);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_addr;
    logic [CW-1:0]     remain;
    logic              past_end;
    logic [CW-1:0]     clamped_count;

    // Budget clamp for a new burst.
    always_comb clamped_count = (burst_count > BURST_CAP) ? BURST_CAP : burst_count;

    // Burst bookkeeping and table storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
            wr_addr  <= '0;
            remain   <= '0;
            past_end <= 1'b0;
        end else if (burst_start) begin
            wr_addr  <= burst_offset;
            remain   <= clamped_count;
            past_end <= 1'b0;
        end else if (byte_vld && (remain != '0)) begin
            remain <= remain - CW'(1);
            if (!past_end) begin
                mem[wr_addr] <= byte_data;
                if (wr_addr == LAST_ENTRY) past_end <= 1'b1;
                else                       wr_addr  <= wr_addr + AW'(1);
            end
        end
    end

    // Table read for the sequencer.
    always_comb rd_data = mem[rd_idx];

    assert_burst_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        remain <= BURST_CAP);

    assert_budget_drains_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !burst_start && remain != '0) |=> remain == $past(remain) - CW'(1));
endmodule

// File: rtl/step_prescaler.sv
// step_prescaler: two cascaded stages that make the table step pulse. Stage
// one counts ticks up from the reload value and overflows after all-ones.
// Stage two counts those overflows down from the divisor. A step happens
// when both stages expire on one tick. A load pulse latches new settings
// and restarts both stages. Assumes tick is a single-cycle enable.
module step_prescaler #(
    parameter int unsigned RELOAD_W = 16,
    parameter int unsigned DIV_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                run,
    input  logic                tick,
    input  logic [RELOAD_W-1:0] reload_val,
    input  logic [DIV_W-1:0]    div_val,
    output logic                step
);
    logic [RELOAD_W-1:0] reload_q;
    logic [DIV_W-1:0]    div_q;
    logic [RELOAD_W-1:0] c_lo;
    logic [DIV_W-1:0]    c_hi;
    logic                lo_wrap;

    // Stage-one expiry and step detection.
    always_comb begin
        lo_wrap = (c_lo == '1);
        step    = run && tick && lo_wrap && (c_hi == '0);
    end

    // Settings latch and both counting stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            div_q    <= '0;
            c_lo     <= '0;
            c_hi     <= '0;
        end else if (load) begin
            reload_q <= reload_val;
            div_q    <= div_val;
            c_lo     <= reload_val;
            c_hi     <= div_val;
        end else if (run && tick) begin
            if (lo_wrap) begin
                c_lo <= reload_q;
                c_hi <= (c_hi == '0) ? div_q : c_hi - DIV_W'(1);
            end else begin
                c_lo <= c_lo + RELOAD_W'(1);
            end
        end
    end

    assert_div_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        c_hi <= div_q);

    assert_idle_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(run && tick)) |=> $stable(c_lo) && $stable(c_hi));
endmodule

// File: rtl/wave_pwm.sv
// wave_pwm: converts a brightness byte to a pulse train. A free-running
// counter is compared with the level, and the result is registered so the
// pin is glitch-free. Assumes the level is held steady for a full period
// when an exact duty is wanted.
module wave_pwm #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] level,
    output logic              pwm
);
    logic [DATA_W-1:0] phase;

    // Free-running phase counter and registered compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            pwm   <= 1'b0;
        end else begin
            phase <= phase + DATA_W'(1);
            pwm   <= (phase < level);
        end
    end

    assert_pwm_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |=> !pwm);
endmodule

// File: rtl/led_wave_seq.sv
// led_wave_seq: top of the LED waveform sequencer. It holds the direct
// brightness register, the run/idle state, the table pointer and the repeat
// flag. It connects the table, the step prescaler and the PWM. A disabling
// control write or cfg_start stops the sequence. An enabling write restarts
// it from entry 0. Assumes all strobes last one cycle.
module led_wave_seq
    import led_seq_pkg::*;
#(
    parameter int unsigned DEPTH     = LS_DEPTH,
    parameter int unsigned DATA_W    = LS_DATA_W,
    parameter int unsigned RELOAD_W  = LS_RELOAD_W,
    parameter int unsigned DIV_W     = LS_DIV_W,
    parameter int unsigned MAX_BURST = LS_MAX_BURST,
    localparam int unsigned AW       = $clog2(DEPTH),
    localparam int unsigned CW       = $clog2(MAX_BURST + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                tbl_start,
    input  logic [AW-1:0]       tbl_offset,
    input  logic [CW-1:0]       tbl_count,
    input  logic                tbl_vld,
    input  logic [DATA_W-1:0]   tbl_data,
    input  logic                ctl_wr,
    input  logic                ctl_enable,
    input  logic [RELOAD_W-1:0] ctl_reload,
    input  logic [DIV_W-1:0]    ctl_div,
    input  logic                ctl_repeat,
    input  logic                bright_wr,
    input  logic [DATA_W-1:0]   bright_data,
    input  logic                cfg_start,
    output logic [DATA_W-1:0]   bright_level,
    output logic                seq_active,
    output logic [AW-1:0]       seq_index,
    output logic                led_pwm
);
    localparam logic [AW-1:0] LAST_ENTRY = AW'(DEPTH - 1);

    seq_state_e        state;
    logic [AW-1:0]     ptr;
    logic              repeat_q;
    logic [DATA_W-1:0] direct_q;
    logic [DATA_W-1:0] tbl_rd;
    logic              step;
    logic              enable_load;
    logic              stop_req;
    logic              running;

    // Decode of control and stop requests; cfg_start wins.
    always_comb begin
        stop_req    = cfg_start || (ctl_wr && !ctl_enable);
        enable_load = ctl_wr && ctl_enable && !cfg_start;
        running     = (state == ST_RUN);
    end

    wave_table #(
        .DEPTH     (DEPTH),
        .DATA_W    (DATA_W),
        .MAX_BURST (MAX_BURST)
    ) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .burst_start  (tbl_start),
        .burst_offset (tbl_offset),
        .burst_count  (tbl_count),
        .byte_vld     (tbl_vld),
        .byte_data    (tbl_data),
        .rd_idx       (ptr),
        .rd_data      (tbl_rd)
    );

    step_prescaler #(
        .RELOAD_W (RELOAD_W),
        .DIV_W    (DIV_W)
    ) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (enable_load),
        .run        (running),
        .tick       (tick_en),
        .reload_val (ctl_reload),
        .div_val    (ctl_div),
        .step       (step)
    );

    // Direct brightness register.
    always_ff @(posedge clk) begin
        if (!rst_n)         direct_q <= '0;
        else if (bright_wr) direct_q <= bright_data;
    end

    // Run state, pointer and repeat flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ptr      <= '0;
            repeat_q <= 1'b0;
        end else if (stop_req) begin
            state <= ST_IDLE;
        end else if (enable_load) begin
            state    <= ST_RUN;
            ptr      <= '0;
            repeat_q <= ctl_repeat;
        end else if (running && step) begin
            if (ptr == LAST_ENTRY) begin
                if (repeat_q) ptr   <= '0;
                else          state <= ST_IDLE;
            end else begin
                ptr <= ptr + AW'(1);
            end
        end
    end

    // Level select: table while running, direct register otherwise.
    always_comb bright_level = running ? tbl_rd : direct_q;

    wave_pwm #(
        .DATA_W (DATA_W)
    ) u_pwm (
        .clk   (clk),
        .rst_n (rst_n),
        .level (bright_level),
        .pwm   (led_pwm)
    );

    assign seq_active = running;
    assign seq_index  = ptr;

    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && step && ptr == LAST_ENTRY && repeat_q && !stop_req && !enable_load)
        |=> (state == ST_RUN) && (ptr == '0));

    assert_oneshot_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && step && ptr == LAST_ENTRY && !repeat_q && !stop_req && !enable_load)
        |=> (state == ST_IDLE) && (ptr == LAST_ENTRY));

    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        enable_load |=> (state == ST_RUN) && (ptr == '0));

    assert_disable_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_enable) |=> state == ST_IDLE);

    assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !enable_load) |=> $stable(ptr));

    assert_cfg_kills_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start |=> state == ST_IDLE);
endmodule

// File: tb/test_led_wave_seq.sv
// Directed bench for led_wave_seq: one task for each scenario, each checking
// its own results against a table model kept in the bench.
module test_led_wave_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        tbl_start = 1'b0;
    logic [5:0]  tbl_offset = '0;
    logic [5:0]  tbl_count = '0;
    logic        tbl_vld = 1'b0;
    logic [7:0]  tbl_data = '0;
    logic        ctl_wr = 1'b0;
    logic        ctl_enable = 1'b0;
    logic [15:0] ctl_reload = '0;
    logic [7:0]  ctl_div = '0;
    logic        ctl_repeat = 1'b0;
    logic        bright_wr = 1'b0;
    logic [7:0]  bright_data = '0;
    logic        cfg_start = 1'b0;
    logic [7:0]  bright_level;
    logic        seq_active;
    logic [5:0]  seq_index;
    logic        led_pwm;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int exp_tbl [64];
    int direct_val = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    led_wave_seq i_led_wave_seq (
        .clk (clk), .rst_n (rst_n), .tick_en (tick_en),
        .tbl_start (tbl_start), .tbl_offset (tbl_offset), .tbl_count (tbl_count),
        .tbl_vld (tbl_vld), .tbl_data (tbl_data),
        .ctl_wr (ctl_wr), .ctl_enable (ctl_enable), .ctl_reload (ctl_reload),
        .ctl_div (ctl_div), .ctl_repeat (ctl_repeat),
        .bright_wr (bright_wr), .bright_data (bright_data), .cfg_start (cfg_start),
        .bright_level (bright_level), .seq_active (seq_active),
        .seq_index (seq_index), .led_pwm (led_pwm)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick_n(int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic set_direct(int v);
        bright_wr = 1'b1; bright_data = 8'(v);
        @(negedge clk);
        bright_wr = 1'b0;
        direct_val = v;
    endtask

    task automatic seq_on(int reload, int div, bit rep);
        ctl_wr = 1'b1; ctl_enable = 1'b1;
        ctl_reload = 16'(reload); ctl_div = 8'(div); ctl_repeat = rep;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_enable = 1'b0;
    endtask

    task automatic seq_off_junk();
        ctl_wr = 1'b1; ctl_enable = 1'b0;
        ctl_reload = 16'h0000; ctl_div = 8'hFF; ctl_repeat = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    // Sends a burst and updates the model by the R2 rules.
    task automatic burst(int off, int cnt, int nbytes, int seed);
        int lim;
        lim = (cnt > 61) ? 61 : cnt;
        tbl_start = 1'b1; tbl_offset = 6'(off); tbl_count = 6'(cnt);
        @(negedge clk);
        tbl_start = 1'b0;
        for (int i = 0; i < nbytes; i++) begin
            tbl_vld = 1'b1; tbl_data = 8'(seed + i * 7);
            @(negedge clk);
            if (i < lim && off + i < 64) exp_tbl[off + i] = (seed + i * 7) & 8'hFF;
        end
        tbl_vld = 1'b0;
        @(negedge clk);
    endtask

    // Plays the whole table at one step per tick and compares each entry.
    task automatic verify_table(string req);
        seq_on(16'hFFFF, 0, 1'b1);
        for (int i = 0; i < 64; i++) begin
            check(req, bright_level, exp_tbl[i]);
            tick_n(1);
        end
        seq_off_junk();
    endtask

    task automatic t_reset();
        check("R1 level", bright_level, 0);
        check("R1 active", seq_active, 0);
        check("R1 index", seq_index, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1 pwm", led_pwm, 0);
        end
        verify_table("R1 table zero");
    endtask

    task automatic t_fill();
        burst(0, 61, 61, 1);
        burst(61, 3, 3, 100);
        verify_table("R2 two-burst fill");
    endtask

    task automatic t_burst_edges();
        burst(0, 63, 63, 50);
        burst(60, 10, 10, 200);
        burst(10, 2, 5, 17);
        verify_table("R2 clamp/overrun/budget");
        check("R2 entry0 not wrapped", exp_tbl[0], (50) & 8'hFF);
    endtask

    task automatic t_rate();
        seq_on(16'hFFFD, 2, 1'b1);
        tick_n(8);
        check("R3 before period", seq_index, 0);
        tick_n(1);
        check("R3 first step", seq_index, 1);
        tick_n(8);
        check("R3 mid second", seq_index, 1);
        tick_n(1);
        check("R3 second step", seq_index, 2);
        check("R3 level", bright_level, exp_tbl[2]);
        seq_off_junk();
    endtask

    task automatic t_repeat();
        seq_on(16'hFFFF, 0, 1'b1);
        tick_n(64);
        check("R4 wrapped index", seq_index, 0);
        check("R4 still active", seq_active, 1);
        check("R4 level", bright_level, exp_tbl[0]);
        tick_n(5);
        check("R4 continues", seq_index, 5);
        seq_off_junk();
    endtask

    task automatic t_oneshot();
        set_direct(8'h19);
        seq_on(16'hFFFF, 0, 1'b0);
        tick_n(63);
        check("R5 at last", seq_index, 63);
        check("R5 active at last", seq_active, 1);
        tick_n(1);
        check("R5 halted", seq_active, 0);
        check("R5 index held", seq_index, 63);
        check("R5 direct level", bright_level, 8'h19);
    endtask

    task automatic t_restart();
        seq_on(16'hFFFF, 0, 1'b1);
        tick_n(10);
        seq_on(16'hFFFD, 0, 1'b1);
        check("R6 index reset", seq_index, 0);
        check("R6 level entry0", bright_level, exp_tbl[0]);
        tick_n(2);
        check("R6 prescaler reloaded", seq_index, 0);
        tick_n(1);
        check("R6 first step", seq_index, 1);
        seq_off_junk();
    endtask

    task automatic t_disable();
        seq_on(16'hFFFF, 0, 1'b1);
        tick_n(7);
        set_direct(8'hFF);
        check("R8 hidden while running", bright_level, exp_tbl[7]);
        seq_off_junk();
        check("R7 stopped", seq_active, 0);
        check("R7 index held", seq_index, 7);
        check("R8 direct shown", bright_level, 8'hFF);
        tick_n(3);
        check("R7 ticks ignored", seq_index, 7);
        set_direct(8'h00);
        check("R8 direct off", bright_level, 0);
    endtask

    task automatic t_cfg();
        seq_on(16'hFFFF, 0, 1'b1);
        tick_n(2);
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        check("R9 cfg stops", seq_active, 0);
        check("R9 level direct", bright_level, direct_val);
        cfg_start = 1'b1; ctl_wr = 1'b1; ctl_enable = 1'b1;
        ctl_reload = 16'hFFFF; ctl_div = 8'h00;
        @(negedge clk);
        cfg_start = 1'b0; ctl_wr = 1'b0; ctl_enable = 1'b0;
        check("R9 cfg beats enable", seq_active, 0);
    endtask

    task automatic pwm_case(int lvl);
        int highs;
        set_direct(lvl);
        repeat (3) @(negedge clk);
        highs = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (led_pwm) highs++;
        end
        check("R10 duty", highs, lvl);
    endtask

    task automatic t_pwm();
        pwm_case(8'h19);
        pwm_case(8'h00);
        pwm_case(8'hFF);
        pwm_case(8'h80);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) exp_tbl[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_burst_edges();
        t_rate();
        t_repeat();
        t_oneshot();
        t_restart();
        t_disable();
        t_cfg();
        t_pwm();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule